// File: doc/BRIEF.md
# Debug Port Register Bank

This block is the register file on the target side of a serial-wire debug port. A protocol front end presents decoded register accesses on a simple request/response interface. The bank answers each access one cycle later. It holds an identification word and a control/status word. That word combines sticky error flags, power and reset request/acknowledge bits, and an overrun-detect enable. The bank also holds an access-port select word and a read buffer for the most recent access-port read result.

Error and compare events arrive as single-cycle pulses, and the control/status word records them as sticky flags. Writes to control/status cannot clear these flags. They clear only through the write-only abort word at address 0x0, which also issues a single-cycle abort pulse toward the access port. Address 0x4 is a banked slot: a four-bit field in the select word chooses which register appears there. Line reset is a single input that discards the read-buffer contents.

Top module: `dbgport_regbank`

## Requirements
- R1: Each request is answered by `rsp_valid` exactly one cycle later. The word address is taken from `req_addr[3:2]`. A read of 0x0 returns the identification constant: revision in [31:28], part number in [27:20], minimal-port flag in [16], version in [15:12], designer code in [11:1], and bit 0 set to 1.
- R2: A write to 0x8 stores the select word: access-port number in [31:24], access-port bank in [7:4], port-bank select in [3:0]. A read of 0x8 returns those fields with all other bits 0. The first two fields drive `ap_sel` and `ap_bank`.
- R3: The port-bank select chooses the register at 0x4. Value 0 selects control/status. Value 1 selects the link control word, whose low `LINK_BITS` bits are writable. Value 2 returns `TARGET_ID`, value 3 returns `PROTO_ID`, and value 4 is an event status word that reads 0. Any other value reads 0. Writes at 0x4 with a select of 2 or more change nothing.
- R4: A write to 0x0 clears sticky flags only for the bits written as 1: bit 4 clears overrun, bit 3 clears write-data error, bit 2 clears sticky error, and bit 1 clears sticky compare.
- R5: Writing 0x0 with bit 0 set raises `ap_abort` for exactly the one cycle after the write. Otherwise `ap_abort` stays low.
- R6: Control/status bit 0 is a writable overrun-detect enable. An `ev_overrun` pulse sets bit 1 only while the enable is 1.
- R7: `ev_ap_err` sets bit 5, `ev_wdata_err` sets bit 7, and `ev_cmp_hit` sets bit 4. Writes to control/status do not change bits 1, 4, 5, 6 or 7.
- R8: Bit 6 takes the value of `ap_rd_ok` on each completed access-port read. On each read of 0xC, bit 6 becomes 1 if the buffer held valid data and 0 if it did not. A completed access-port read takes precedence over a read of 0xC in the same cycle.
- R9: Bits 30, 28 and 26 are writable system power-up, debug power-up and debug reset requests. They drive `sys_pwr_req`, `dbg_pwr_req` and `dbg_rst_req`. Bits 31, 29 and 27 read back `sys_pwr_ack`, `dbg_pwr_ack` and `dbg_rst_ack`.
- R10: After `rst_n` all of the following are 0: every sticky flag, the read-OK bit, the overrun enable, the request outputs, the select word, the link control word and `ap_abort`. The read buffer is empty.
- R11: Each completed access-port read loads the read buffer. The first read of 0xC returns that data. Later reads return 0 until the next completed access-port read. A pulse on `line_reset` empties the buffer.
- R12: When an event and an abort-word clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| line_reset | input | 1 | Line reset pulse; empties the read buffer |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register byte address (0x0, 0x4, 0x8, 0xC) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 32 | Read data |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_wdata_err | input | 1 | Write data-phase parity/framing error pulse |
| ev_ap_err | input | 1 | Access-port transaction error pulse |
| ev_cmp_hit | input | 1 | Compare hit pulse |
| ap_rd_done | input | 1 | Access-port read completed |
| ap_rd_ok | input | 1 | Completed access-port read had an OK response |
| ap_rd_data | input | 32 | Data of the completed access-port read |
| sys_pwr_ack | input | 1 | System power-up acknowledge |
| dbg_pwr_ack | input | 1 | Debug power-up acknowledge |
| dbg_rst_ack | input | 1 | Debug reset acknowledge |
| sys_pwr_req | output | 1 | System power-up request |
| dbg_pwr_req | output | 1 | Debug power-up request |
| dbg_rst_req | output | 1 | Debug reset request |
| ap_abort | output | 1 | Single-cycle abort pulse to the access port |
| ap_sel | output | 8 | Selected access port |
| ap_bank | output | 4 | Selected access-port register bank |

## Verification
The bench builds the bank with distinctive identification fields: revision 0x9, part number 0x5C, version 2, minimal-port flag 1 and designer code 0x23B. It also uses its own target and protocol identifiers, and a link control width of 10 bits. These values make every field of the identification word visibly placed, and they make the writable mask of the link word observable. With these settings the bench can sweep all sixteen port-bank select values at address 0x4. It can also sweep all thirty-two abort patterns against a full set of sticky flags, so every clear combination and every reserved bank is reached.

// File: rtl/dbgport_pkg.sv
package dbgport_pkg;

  typedef enum logic [3:0] {
    TGT_ID_ABORT,
    TGT_CTRL,
    TGT_LINK,
    TGT_TARGET,
    TGT_PROTO,
    TGT_EVSTAT,
    TGT_SELECT,
    TGT_RDBUF,
    TGT_NONE
  } reg_target_e;

  // Identification word: fields placed where a host decodes them.
  function automatic logic [31:0] make_id(input logic [3:0] rev, input logic [7:0] part,
                                          input logic minp, input logic [3:0] ver,
                                          input logic [10:0] designer);
    make_id = {rev, part, 3'b000, minp, ver, designer, 1'b1};
  endfunction

  // Control/status word from its individual bits.
  function automatic logic [31:0] pack_ctrl(input logic sys_ack, input logic sys_req,
                                            input logic dbg_ack, input logic dbg_req,
                                            input logic rst_ack, input logic rst_req,
                                            input logic wderr, input logic rdok,
                                            input logic sterr, input logic stcmp,
                                            input logic orun, input logic orun_en);
    pack_ctrl = {sys_ack, sys_req, dbg_ack, dbg_req, rst_ack, rst_req,
                 18'd0, wderr, rdok, sterr, stcmp, 2'b00, orun, orun_en};
  endfunction

  function automatic logic [31:0] low_mask(input int unsigned bits);
    low_mask = (bits >= 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
  endfunction

endpackage

// File: rtl/dbgport_decode.sv
module dbgport_decode
  import dbgport_pkg::*;
#(
  parameter int unsigned BANK_W = 4
) (
  input  logic [3:0]        addr,
  input  logic [BANK_W-1:0] dp_bank,
  output reg_target_e       target
);
  localparam logic [BANK_W-1:0] B_CTRL = BANK_W'(0);
  localparam logic [BANK_W-1:0] B_LINK = BANK_W'(1);
  localparam logic [BANK_W-1:0] B_TGT  = BANK_W'(2);
  localparam logic [BANK_W-1:0] B_PROT = BANK_W'(3);
  localparam logic [BANK_W-1:0] B_EVT  = BANK_W'(4);

  always_comb begin
    target = TGT_NONE;
    unique case (addr[3:2])
      2'd0: target = TGT_ID_ABORT;
      2'd1: begin
        if      (dp_bank == B_CTRL) target = TGT_CTRL;
        else if (dp_bank == B_LINK) target = TGT_LINK;
        else if (dp_bank == B_TGT)  target = TGT_TARGET;
        else if (dp_bank == B_PROT) target = TGT_PROTO;
        else if (dp_bank == B_EVT)  target = TGT_EVSTAT;
        else                        target = TGT_NONE;
      end
      2'd2: target = TGT_SELECT;
      2'd3: target = TGT_RDBUF;
      default: target = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/dbgport_ctrlstat.sv
module dbgport_ctrlstat
  import dbgport_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ctrl,
  input  logic        wr_abort,
  input  logic [31:0] wdata,
  input  logic        ev_overrun,
  input  logic        ev_wdata_err,
  input  logic        ev_ap_err,
  input  logic        ev_cmp_hit,
  input  logic        ap_rd_done,
  input  logic        ap_rd_ok,
  input  logic        buf_rd,
  input  logic        buf_was_valid,
  input  logic        sys_pwr_ack,
  input  logic        dbg_pwr_ack,
  input  logic        dbg_rst_ack,
  output logic        sys_pwr_req,
  output logic        dbg_pwr_req,
  output logic        dbg_rst_req,
  output logic        ap_abort,
  output logic [31:0] ctrl_word
);
  logic orun_en_q, orun_q, wderr_q, sterr_q, stcmp_q, rdok_q;

  // Named internal events for the checks below.
  logic set_orun, clr_orun, clr_wderr, clr_sterr, clr_stcmp;
  assign set_orun  = ev_overrun & orun_en_q;
  assign clr_orun  = wr_abort & wdata[4];
  assign clr_wderr = wr_abort & wdata[3];
  assign clr_sterr = wr_abort & wdata[2];
  assign clr_stcmp = wr_abort & wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orun_en_q <= 1'b0; orun_q <= 1'b0; wderr_q <= 1'b0;
      sterr_q <= 1'b0; stcmp_q <= 1'b0; rdok_q <= 1'b0;
      sys_pwr_req <= 1'b0; dbg_pwr_req <= 1'b0; dbg_rst_req <= 1'b0;
      ap_abort <= 1'b0;
    end else begin
      // Set beats clear so no event is lost.
      orun_q  <= set_orun     | (orun_q  & ~clr_orun);
      wderr_q <= ev_wdata_err | (wderr_q & ~clr_wderr);
      sterr_q <= ev_ap_err    | (sterr_q & ~clr_sterr);
      stcmp_q <= ev_cmp_hit   | (stcmp_q & ~clr_stcmp);
      if (ap_rd_done)  rdok_q <= ap_rd_ok;
      else if (buf_rd) rdok_q <= buf_was_valid;
      if (wr_ctrl) begin
        orun_en_q   <= wdata[0];
        dbg_rst_req <= wdata[26];
        dbg_pwr_req <= wdata[28];
        sys_pwr_req <= wdata[30];
      end
      ap_abort <= wr_abort & wdata[0];
    end
  end

  assign ctrl_word = pack_ctrl(sys_pwr_ack, sys_pwr_req, dbg_pwr_ack, dbg_pwr_req,
                               dbg_rst_ack, dbg_rst_req, wderr_q, rdok_q,
                               sterr_q, stcmp_q, orun_q, orun_en_q);

  // R6
  orun_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!orun_en_q && !orun_q) |=> !orun_q);
  // R12
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ap_err |=> sterr_q);
  // R5
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_abort && wdata[0]) |=> ap_abort);
  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wderr && !ev_wdata_err) |=> !wderr_q);
endmodule

// File: rtl/dbgport_rdbuf.sv
module dbgport_rdbuf #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_reset,
  input  logic              cap,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              valid
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      valid  <= 1'b0;
    end else if (line_reset) begin
      valid <= 1'b0;
    end else if (cap) begin
      data_q <= cap_data;
      valid  <= 1'b1;
    end else if (rd) begin
      valid <= 1'b0;
    end
  end

  assign rd_data = valid ? data_q : '0;

  // R11
  consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !cap) |=> !valid);
  // R11
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !line_reset) |=> (valid && rd_data == $past(cap_data)));
endmodule

// File: rtl/dbgport_regbank.sv
module dbgport_regbank
  import dbgport_pkg::*;
#(
  parameter logic [3:0]  ID_REV      = 4'h1,
  parameter logic [7:0]  ID_PART     = 8'hBA,
  parameter logic        ID_MINIMAL  = 1'b0,
  parameter logic [3:0]  ID_VERSION  = 4'h2,
  parameter logic [10:0] ID_DESIGNER = 11'h23B,
  parameter logic [31:0] TARGET_ID   = 32'h1000_2927,
  parameter logic [31:0] PROTO_ID    = 32'h0000_0001,
  parameter int unsigned LINK_BITS   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_reset,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [3:0]  req_addr,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  input  logic        ev_overrun,
  input  logic        ev_wdata_err,
  input  logic        ev_ap_err,
  input  logic        ev_cmp_hit,
  input  logic        ap_rd_done,
  input  logic        ap_rd_ok,
  input  logic [31:0] ap_rd_data,
  input  logic        sys_pwr_ack,
  input  logic        dbg_pwr_ack,
  input  logic        dbg_rst_ack,
  output logic        sys_pwr_req,
  output logic        dbg_pwr_req,
  output logic        dbg_rst_req,
  output logic        ap_abort,
  output logic [7:0]  ap_sel,
  output logic [3:0]  ap_bank
);
  localparam int unsigned BANK_W   = 4;
  localparam logic [31:0] LINK_MSK = low_mask(LINK_BITS);
  localparam logic [31:0] ID_WORD  = make_id(ID_REV, ID_PART, ID_MINIMAL, ID_VERSION, ID_DESIGNER);

  reg_target_e       target;
  logic [BANK_W-1:0] dp_bank_q;
  logic [31:0]       link_q, ctrl_word, buf_data, rd_mux;
  logic              buf_valid;
  logic              wr, rd, wr_abort, wr_ctrl, wr_link, wr_sel, buf_rd;

  dbgport_decode #(.BANK_W(BANK_W)) i_decode (
    .addr(req_addr), .dp_bank(dp_bank_q), .target(target));

  assign wr       = req_valid & req_write;
  assign rd       = req_valid & ~req_write;
  assign wr_abort = wr & (target == TGT_ID_ABORT);
  assign wr_ctrl  = wr & (target == TGT_CTRL);
  assign wr_link  = wr & (target == TGT_LINK);
  assign wr_sel   = wr & (target == TGT_SELECT);
  assign buf_rd   = rd & (target == TGT_RDBUF);

  dbgport_ctrlstat i_ctrlstat (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_abort(wr_abort), .wdata(req_wdata),
    .ev_overrun(ev_overrun), .ev_wdata_err(ev_wdata_err), .ev_ap_err(ev_ap_err),
    .ev_cmp_hit(ev_cmp_hit), .ap_rd_done(ap_rd_done), .ap_rd_ok(ap_rd_ok),
    .buf_rd(buf_rd), .buf_was_valid(buf_valid), .sys_pwr_ack(sys_pwr_ack),
    .dbg_pwr_ack(dbg_pwr_ack), .dbg_rst_ack(dbg_rst_ack), .sys_pwr_req(sys_pwr_req),
    .dbg_pwr_req(dbg_pwr_req), .dbg_rst_req(dbg_rst_req), .ap_abort(ap_abort),
    .ctrl_word(ctrl_word));

  dbgport_rdbuf #(.DATA_W(32)) i_rdbuf (
    .clk(clk), .rst_n(rst_n), .line_reset(line_reset), .cap(ap_rd_done),
    .cap_data(ap_rd_data), .rd(buf_rd), .rd_data(buf_data), .valid(buf_valid));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_sel <= '0; ap_bank <= '0; dp_bank_q <= '0; link_q <= '0;
    end else begin
      if (wr_sel) begin
        ap_sel    <= req_wdata[31:24];
        ap_bank   <= req_wdata[7:4];
        dp_bank_q <= req_wdata[3:0];
      end
      if (wr_link) link_q <= req_wdata & LINK_MSK;
    end
  end

  always_comb begin
    unique case (target)
      TGT_ID_ABORT: rd_mux = ID_WORD;
      TGT_CTRL:     rd_mux = ctrl_word;
      TGT_LINK:     rd_mux = link_q;
      TGT_TARGET:   rd_mux = TARGET_ID;
      TGT_PROTO:    rd_mux = PROTO_ID;
      TGT_SELECT:   rd_mux = {ap_sel, 16'd0, ap_bank, dp_bank_q};
      TGT_RDBUF:    rd_mux = buf_data;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd ? rd_mux : '0;
    end
  end

  // R1
  resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (target == TGT_NONE || target == TGT_EVSTAT)) |=> (rsp_rdata == 32'd0));
  // R2
  select_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> ($stable(ap_sel) && $stable(ap_bank)));
endmodule

// File: tb/test_dbgport_regbank.sv
`timescale 1ns/1ps
module test_dbgport_regbank;
  localparam logic [3:0]  P_REV  = 4'h9;
  localparam logic [7:0]  P_PART = 8'h5C;
  localparam logic        P_MIN  = 1'b1;
  localparam logic [3:0]  P_VER  = 4'h2;
  localparam logic [10:0] P_DES  = 11'h23B;
  localparam logic [31:0] P_TGT  = 32'hC0DE_1F03;
  localparam logic [31:0] P_PROT = 32'h3000_0001;
  localparam int unsigned P_LINK = 10;

  logic clk = 1'b0, rst_n = 1'b0, line_reset = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid; logic [31:0] rsp_rdata;
  logic ev_overrun = 0, ev_wdata_err = 0, ev_ap_err = 0, ev_cmp_hit = 0;
  logic ap_rd_done = 0, ap_rd_ok = 0; logic [31:0] ap_rd_data = '0;
  logic sys_pwr_ack = 0, dbg_pwr_ack = 0, dbg_rst_ack = 0;
  logic sys_pwr_req, dbg_pwr_req, dbg_rst_req, ap_abort;
  logic [7:0] ap_sel; logic [3:0] ap_bank;

  int checks = 0, failures = 0;
  logic last_abort;

  always #2.5 clk = ~clk;

  dbgport_regbank #(.ID_REV(P_REV), .ID_PART(P_PART), .ID_MINIMAL(P_MIN), .ID_VERSION(P_VER),
    .ID_DESIGNER(P_DES), .TARGET_ID(P_TGT), .PROTO_ID(P_PROT), .LINK_BITS(P_LINK)) i_dbgport_regbank (
    .clk(clk), .rst_n(rst_n), .line_reset(line_reset), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ev_overrun(ev_overrun),
    .ev_wdata_err(ev_wdata_err), .ev_ap_err(ev_ap_err), .ev_cmp_hit(ev_cmp_hit),
    .ap_rd_done(ap_rd_done), .ap_rd_ok(ap_rd_ok), .ap_rd_data(ap_rd_data),
    .sys_pwr_ack(sys_pwr_ack), .dbg_pwr_ack(dbg_pwr_ack), .dbg_rst_ack(dbg_rst_ack),
    .sys_pwr_req(sys_pwr_req), .dbg_pwr_req(dbg_pwr_req), .dbg_rst_req(dbg_rst_req),
    .ap_abort(ap_abort), .ap_sel(ap_sel), .ap_bank(ap_bank));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    last_abort = ap_abort;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic pulse_events(input logic [3:0] m);
    @(negedge clk);
    {ev_overrun, ev_wdata_err, ev_ap_err, ev_cmp_hit} = m;
    @(negedge clk);
    {ev_overrun, ev_wdata_err, ev_ap_err, ev_cmp_hit} = 4'b0;
  endtask

  task automatic ap_read(input logic ok, input logic [31:0] d);
    @(negedge clk);
    ap_rd_done = 1; ap_rd_ok = ok; ap_rd_data = d;
    @(negedge clk);
    ap_rd_done = 0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d, exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    check("R10 outputs", {26'd0, sys_pwr_req, dbg_pwr_req, dbg_rst_req, ap_abort, 2'b0}, 32'd0);
    rd_reg(4'h4, d); check("R10 ctrl", d, 32'd0);
    rd_reg(4'h8, d); check("R10 select", d, 32'd0);
    rd_reg(4'hC, d); check("R10 rdbuf", d, 32'd0);
    // R1 identification
    exp = (32'(P_REV) << 28) | (32'(P_PART) << 20) | (32'(P_MIN) << 16)
        | (32'(P_VER) << 12) | (32'(P_DES) << 1) | 32'd1;
    rd_reg(4'h0, d); check("R1 id", d, exp);
    // R2 select fields
    wr_reg(4'h8, 32'hA5A5_A5A5);
    rd_reg(4'h8, d); check("R2 select", d, 32'hA500_00A5);
    check("R2 ap_sel", {24'd0, ap_sel}, 32'hA5);
    check("R2 ap_bank", {28'd0, ap_bank}, 32'hA);
    // R3 link control write through bank 1
    wr_reg(4'h8, 32'h0000_0001);
    wr_reg(4'h4, 32'hFFFF_FFFF);
    // R3 bank sweep
    for (int b = 0; b < 16; b++) begin
      wr_reg(4'h8, 32'(b));
      rd_reg(4'h4, d);
      case (b)
        0: exp = 32'd0;
        1: exp = (32'd1 << P_LINK) - 1;
        2: exp = P_TGT;
        3: exp = P_PROT;
        default: exp = 32'd0;
      endcase
      check($sformatf("R3 bank %0d", b), d, exp);
    end
    // R3 write at reserved bank changes nothing
    wr_reg(4'h8, 32'd2); wr_reg(4'h4, 32'h5400_0001);
    wr_reg(4'h8, 32'd0); rd_reg(4'h4, d);
    check("R3 ignored write", d, 32'd0);
    // R9 requests and ack mirrors
    wr_reg(4'h4, 32'h5400_0000);
    check("R9 req outs", {29'd0, sys_pwr_req, dbg_pwr_req, dbg_rst_req}, 32'd7);
    sys_pwr_ack = 1; dbg_pwr_ack = 1; dbg_rst_ack = 1;
    rd_reg(4'h4, d); check("R9 ctrl", d, 32'hFC00_0000);
    // R6 overrun gated by enable
    pulse_events(4'b1000);
    rd_reg(4'h4, d); check("R6 disabled", d & 32'h2, 32'd0);
    wr_reg(4'h4, 32'h5400_0001);
    pulse_events(4'b1000);
    rd_reg(4'h4, d); check("R6 enabled", d & 32'h3, 32'h3);
    // R7 events and write-immunity
    pulse_events(4'b0111);
    wr_reg(4'h4, 32'h5400_0001 & ~32'hB2);
    wr_reg(4'h4, 32'h5400_00F3);
    rd_reg(4'h4, d); check("R7 sticky", d & 32'hB2, 32'hB2);
    // R4 / R5 abort sweep
    for (int m = 0; m < 32; m++) begin
      pulse_events(4'b1111);
      wr_reg(4'h0, 32'(m));
      check($sformatf("R5 abort m=%0d", m), {31'd0, last_abort}, {31'd0, m[0]});
      rd_reg(4'h4, d);
      exp = (m[4] ? 32'd0 : 32'h02) | (m[3] ? 32'd0 : 32'h80)
          | (m[2] ? 32'd0 : 32'h20) | (m[1] ? 32'd0 : 32'h10);
      check($sformatf("R4 clear m=%0d", m), d & 32'hB2, exp);
    end
    @(negedge clk); check("R5 single cycle", {31'd0, ap_abort}, 32'd0);
    // R12 event wins over clear
    wr_reg(4'h0, 32'h1E);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 4'h0; req_wdata = 32'h04; ev_ap_err = 1;
    @(negedge clk);
    req_valid = 0; req_write = 0; ev_ap_err = 0;
    rd_reg(4'h4, d); check("R12 event wins", d & 32'h20, 32'h20);
    // R8 / R11 read OK and read buffer
    ap_read(1'b1, 32'h1234_5678);
    rd_reg(4'h4, d); check("R8 ok", d & 32'h40, 32'h40);
    rd_reg(4'hC, d); check("R11 first read", d, 32'h1234_5678);
    rd_reg(4'h4, d); check("R8 buffer valid", d & 32'h40, 32'h40);
    rd_reg(4'hC, d); check("R11 second read", d, 32'd0);
    rd_reg(4'h4, d); check("R8 buffer empty", d & 32'h40, 32'd0);
    ap_read(1'b0, 32'hDEAD_BEEF);
    rd_reg(4'h4, d); check("R8 not ok", d & 32'h40, 32'd0);
    ap_read(1'b1, 32'h0BAD_F00D);
    @(negedge clk); line_reset = 1; @(negedge clk); line_reset = 0;
    rd_reg(4'hC, d); check("R11 line reset", d, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule